// File: doc/BRIEF.md
# Twelve-Hour Time-of-Day Counter

This block keeps wall-clock time in a 12-hour format from a single system clock and a one-cycle enable that pulses once per second. It holds seconds and minutes as pairs of BCD digits. The hour is held as a one-bit tens digit and a four-bit units digit, running from 1 to 12. A separate flag marks morning or afternoon. Every digit is a register that drives a port directly, so each one can feed a 7-segment decoder with no binary-to-decimal stage in between.

On each enabled cycle the seconds advance by one. A wrap of the seconds from 59 to 00 advances the minutes, and a wrap of the minutes from 59 to 00 advances the hour. The meridiem flag flips at the moment the hour steps from 11 to 12. A synchronous reset loads 12:00:00 in the morning.

Top module: `clock12_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next state is 12:00:00 morning (hour tens 1, hour units 2, all minute and second digits 0, `is_am` 1), whatever the value of `tick`.
- R2: On a clock edge where `tick` is low and `rst` is low, no output changes.
- R3: On each enabled edge the seconds units digit advances by one. From 9 it returns to 0 and the seconds tens digit advances, and the seconds tens digit runs 0 to 5.
- R4: The minute digits count with the same ranges as the seconds digits. They advance only on an enabled edge where the seconds read 59, and on that edge the seconds become 00.
- R5: The hour advances by one only on an enabled edge where the minutes and seconds read 59:59. The hour is given as `hr_tens` (0 or 1) and `hr_ones` (BCD).
- R6: Hour 9 (tens 0, units 9) is followed by hour 10 (tens 1, units 0).
- R7: Hour 12 (tens 1, units 2) is followed by hour 1 (tens 0, units 1).
- R8: `is_am` (1 = morning, 0 = afternoon) inverts exactly when the hour steps from 11 to 12 and holds on every other edge. 11:59:59 morning is followed by 12:00:00 afternoon, and the reverse.
- R9: Outside reset the outputs only show legal values: seconds and minutes units 0 to 9, tens 0 to 5, hour 1 to 9 with tens 0 or 10 to 12 with tens 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for every register |
| rst | input | 1 | Synchronous reset, active high, loads 12:00:00 morning |
| tick | input | 1 | One-cycle enable, high once per second |
| sec_ones | output | 4 | Seconds units digit, BCD |
| sec_tens | output | 3 | Seconds tens digit, 0 to 5 |
| min_ones | output | 4 | Minutes units digit, BCD |
| min_tens | output | 3 | Minutes tens digit, 0 to 5 |
| hr_ones | output | 4 | Hour units digit, BCD |
| hr_tens | output | 1 | Hour tens digit, 0 or 1 |
| is_am | output | 1 | 1 for morning, 0 for afternoon |

## Verification
On every cycle the assertions check that the digits stay in their legal ranges and that nothing moves without an enable. They also check that the minutes hold except at a seconds wrap, that the hour steps 9 to 10 and 12 to 1 across a full wrap, and that the meridiem flag changes only when the hour lands on 12. Exact counting order is shown only by the bench. It steps through a whole day plus a margin, compares every displayed time with a value computed from elapsed seconds, inserts idle gaps, and applies a reset while the enable is high.

// File: rtl/clock12_counter.sv
module clock12_counter (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  output logic [3:0] sec_ones,
  output logic [2:0] sec_tens,
  output logic [3:0] min_ones,
  output logic [2:0] min_tens,
  output logic [3:0] hr_ones,
  output logic       hr_tens,
  output logic       is_am
);

  logic s1_top, sec_top, m1_top, min_top, adv_min, adv_hr;

  assign s1_top  = (sec_ones == 4'd9);
  assign sec_top = s1_top && (sec_tens == 3'd5);
  assign m1_top  = (min_ones == 4'd9);
  assign min_top = m1_top && (min_tens == 3'd5);
  assign adv_min = tick && sec_top;
  assign adv_hr  = adv_min && min_top;

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_ones <= 4'd0;
      sec_tens <= 3'd0;
    end else if (tick) begin
      sec_ones <= s1_top ? 4'd0 : sec_ones + 4'd1;
      if (s1_top) sec_tens <= (sec_tens == 3'd5) ? 3'd0 : sec_tens + 3'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      min_ones <= 4'd0;
      min_tens <= 3'd0;
    end else if (adv_min) begin
      min_ones <= m1_top ? 4'd0 : min_ones + 4'd1;
      if (m1_top) min_tens <= (min_tens == 3'd5) ? 3'd0 : min_tens + 3'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hr_tens <= 1'b1;
      hr_ones <= 4'd2;
      is_am   <= 1'b1;
    end else if (adv_hr) begin
      if (hr_tens && hr_ones == 4'd2) begin
        hr_tens <= 1'b0;
        hr_ones <= 4'd1;
      end else if (hr_tens && hr_ones == 4'd1) begin
        hr_ones <= 4'd2;
        is_am   <= ~is_am;
      end else if (hr_ones == 4'd9) begin
        hr_tens <= 1'b1;
        hr_ones <= 4'd0;
      end else begin
        hr_ones <= hr_ones + 4'd1;
      end
    end
  end

  // R1
  reset_load_chk: assert property (@(posedge clk) rst |=>
    (hr_tens && hr_ones == 4'd2 && min_tens == 3'd0 && min_ones == 4'd0 &&
     sec_tens == 3'd0 && sec_ones == 4'd0 && is_am));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable({sec_ones, sec_tens, min_ones, min_tens, hr_ones, hr_tens, is_am}));

  // R3
  sec_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && sec_ones != 4'd9) |=> sec_ones == $past(sec_ones) + 4'd1);

  // R4
  min_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(tick && sec_ones == 4'd9 && sec_tens == 3'd5) |=> $stable({min_ones, min_tens}));

  // R5
  hr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(tick && sec_ones == 4'd9 && sec_tens == 3'd5 && min_ones == 4'd9 && min_tens == 3'd5)
    |=> $stable({hr_ones, hr_tens}));

  // R6
  nine_to_ten_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && sec_ones == 4'd9 && sec_tens == 3'd5 && min_ones == 4'd9 && min_tens == 3'd5 &&
     !hr_tens && hr_ones == 4'd9) |=> (hr_tens && hr_ones == 4'd0));

  // R7
  twelve_to_one_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && sec_ones == 4'd9 && sec_tens == 3'd5 && min_ones == 4'd9 && min_tens == 3'd5 &&
     hr_tens && hr_ones == 4'd2) |=> (!hr_tens && hr_ones == 4'd1));

  // R8
  meridiem_chk: assert property (@(posedge clk) disable iff (rst)
    (is_am != $past(is_am)) |-> (hr_tens && hr_ones == 4'd2 && $past(hr_ones) == 4'd1));

  // R9
  legal_range_chk: assert property (@(posedge clk) disable iff (rst)
    (sec_ones <= 4'd9 && sec_tens <= 3'd5 && min_ones <= 4'd9 && min_tens <= 3'd5 &&
     (hr_tens ? hr_ones <= 4'd2 : (hr_ones >= 4'd1 && hr_ones <= 4'd9))));

endmodule

// File: tb/clock12_counter_tb.sv
module clock12_counter_tb;
  logic clk = 1'b0;
  logic rst, tick;
  logic [3:0] sec_ones, min_ones, hr_ones;
  logic [2:0] sec_tens, min_tens;
  logic hr_tens, is_am;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  clock12_counter u_dut (
    .clk(clk), .rst(rst), .tick(tick),
    .sec_ones(sec_ones), .sec_tens(sec_tens),
    .min_ones(min_ones), .min_tens(min_tens),
    .hr_ones(hr_ones), .hr_tens(hr_tens), .is_am(is_am)
  );

  function automatic logic [19:0] expect_at(int secs);
    int t, h24, h12, m, s;
    t   = secs % 86400;
    h24 = t / 3600;
    h12 = (h24 % 12 == 0) ? 12 : h24 % 12;
    m   = (t / 60) % 60;
    s   = t % 60;
    return {1'(h12 / 10), 4'(h12 % 10), 3'(m / 10), 4'(m % 10),
            3'(s / 10), 4'(s % 10), 1'(h24 < 12)};
  endfunction

  task automatic check_time(int secs, string tag);
    logic [19:0] got, exp;
    got = {hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones, is_am};
    exp = expect_at(secs);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s at t=%0d: got %h expected %h", tag, secs, got, exp);
    end
    n_chk++;
    if (!(sec_ones <= 9 && sec_tens <= 5 && min_ones <= 9 && min_tens <= 5 &&
          (hr_tens ? hr_ones <= 2 : (hr_ones >= 1 && hr_ones <= 9)))) begin
      n_bad++;
      $display("FAIL R9 at t=%0d: got %h expected legal digits", secs, got);
    end
  endtask

  function automatic string tag_for(int secs);
    int t, h12;
    t = secs % 86400;
    h12 = ((t / 3600) % 12 == 0) ? 12 : (t / 3600) % 12;
    if (t % 3600 == 0) begin
      if (h12 == 12) return "R8";
      if (h12 == 1)  return "R7";
      if (h12 == 10) return "R6";
      return "R5";
    end
    if (t % 60 == 0) return "R4";
    return "R3";
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    int count;
    rst = 1'b1;
    tick = 1'b0;
    repeat (3) @(negedge clk);
    check_time(0, "R1");
    rst = 1'b0;
    count = 0;
    for (int i = 0; i < 86410; i++) begin
      tick = 1'b1;
      @(negedge clk);
      count++;
      check_time(count, tag_for(count));
      tick = 1'b0;
      if (i % 997 == 0 || count % 43200 == 0) begin
        repeat (3) @(negedge clk);
        check_time(count, "R2");
      end
    end
    tick = 1'b1;
    repeat (100) @(negedge clk);
    count += 100;
    check_time(count, "R3");
    rst = 1'b1;
    @(negedge clk);
    check_time(0, "R1");
    rst = 1'b0;
    tick = 1'b0;
    @(negedge clk);
    check_time(0, "R2");
    done = 1;
    finish_run();
  end
endmodule